// File: doc/BRIEF.md
# Transfer Unit Payload Packer

The packer turns a stream of pixel symbols into a link symbol stream cut into fixed-length transfer units. Each unit opens with a run of payload symbols. The rest of the unit is stuffing. The stuffing region is framed by a fill-start control symbol and a fill-end control symbol, with zero symbols between them. The block does not send data in bursts. It spreads the payload evenly, so every unit carries the same number of payload symbols, give or take one. A downstream sink therefore never has to take data faster than the average stream rate.

The payload count of each unit comes from a programmed ratio, which has an integer part and a fractional part. A fractional accumulator adds the fractional part once per unit. When the addition overflows, that unit carries one extra payload symbol, so over many units the average equals the programmed ratio. Upstream logic offers symbols on a valid/ready interface and is pulled only during payload slots. Downstream logic receives exactly one symbol per clock, with a flag that marks control symbols.

Top module: `tu_packer`

## Requirements
- R1: While reset is held, and in the first clock after it is released, `out_valid`, `out_ctrl` and `out_underflow` are 0 and `out_sym` is 0.
- R2: The unit length is `cfg_tu_len` clamped to the range 32..64. A value below 32 gives 32 and a value above 64 gives 64. Fill-end symbols of consecutive units are exactly one unit length apart.
- R3: The first P slots of every unit are payload slots. P = `cfg_pay_int` + carry, where carry is the accumulator overflow for that unit.
- R4: The accumulator starts at 0 after reset and adds `cfg_pay_frac` (8-bit fraction) once per unit. After K units from reset, the number of payload slots equals K·int + floor(K·frac/256), unless the clamp of R7 applies.
- R5: When the stuffing region (length minus P) is 2 or more, slot P carries fill-start (0xF1, ctrl=1). The last slot carries fill-end (0xF2, ctrl=1). The slots between them carry 0x00 with ctrl=0. No fill-start is ever followed directly by another fill-start.
- R6: When the stuffing region is exactly 1 slot, that last slot carries fill-end only, and no fill-start is sent.
- R7: When P is equal to or greater than the unit length, P is clamped to the length. The whole unit is then payload, with no control symbols.
- R8: `in_ready` is 1 exactly during payload slots. An input symbol is consumed only when `in_valid` and `in_ready` are both 1, and consumed symbols appear in input order.
- R9: In a payload slot where `in_valid` is 0, the output for that slot is 0x00 with ctrl=0 and `out_underflow`=1. Otherwise `out_underflow` is 0.
- R10: The symbol for a slot appears on `out_sym`/`out_ctrl` one clock after that slot, with `out_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tu_len | input | 7 | Requested unit length in symbols (clamped to 32..64) |
| cfg_pay_int | input | 7 | Integer part of the payload symbols per unit |
| cfg_pay_frac | input | 8 | Fractional part of the payload symbols per unit, in 1/256 steps |
| in_valid | input | 1 | Input symbol offered |
| in_ready | output | 1 | Current slot takes a payload symbol |
| in_data | input | 8 | Input pixel symbol |
| out_valid | output | 1 | Output symbol valid (from the first slot after reset on) |
| out_sym | output | 8 | Output link symbol |
| out_ctrl | output | 1 | Output symbol is a control code |
| out_underflow | output | 1 | A payload slot found no input data |

## Verification
`in_ready` is combinational on the current slot and holds in the same cycle as the inputs that slot sees. The symbol, control flag and underflow flag for a slot are registered and are due one clock later. The bench drives inputs just after a falling edge and checks `in_ready` a moment later against its model of the current slot. At the next falling edge it compares the registered outputs with the value the model predicted for that slot. Payload-slot totals per configuration and fill-end spacing are counted over whole units started from reset, so the accumulator and clamp results can be compared with closed-form values.

// File: rtl/tu_pkg.sv
// Shared types for the transfer unit packer.
// Assumes: nothing beyond IEEE 1800-2017.
package tu_pkg;
    // Kind of symbol a slot within a unit carries.
    typedef enum logic [1:0] {
        SLOT_PAY  = 2'd0,
        SLOT_FS   = 2'd1,
        SLOT_FE   = 2'd2,
        SLOT_ZERO = 2'd3
    } slot_t;
endpackage

// File: rtl/tu_ratio_acc.sv
// Fractional ratio accumulator: once per unit, adds the fractional part of the
// payload ratio. On overflow it grants one extra payload symbol to that unit.
// The result is clamped to the unit length.
// Assumes: step is high for one cycle at the first slot of each unit.
module tu_ratio_acc #(
    parameter int LEN_W  = 7,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [LEN_W-1:0]  pay_int,
    input  logic [FRAC_W-1:0] pay_frac,
    input  logic [LEN_W-1:0]  unit_len,
    output logic [LEN_W-1:0]  pay_cnt
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;
    logic [LEN_W:0]    raw_cnt;

    // Sum for this unit, and its payload count with the clamp to the unit length.
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, pay_frac};
        raw_cnt = {1'b0, pay_int} + {{LEN_W{1'b0}}, sum[FRAC_W]};
        if (raw_cnt > {1'b0, unit_len})
            pay_cnt = unit_len;
        else
            pay_cnt = raw_cnt[LEN_W-1:0];
    end

    // Keep the fractional remainder from one unit to the next.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (step)
            acc_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/tu_slot_ctr.sv
// Slot position counter. It tracks the slot index within the current unit and
// latches the unit length and payload count at the first slot of each unit.
// Assumes: len_new >= 1 and pay_new <= len_new.
module tu_slot_ctr #(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_new,
    input  logic [LEN_W-1:0] pay_new,
    output logic             unit_start,
    output logic [LEN_W-1:0] pos,
    output logic [LEN_W-1:0] eff_len,
    output logic [LEN_W-1:0] eff_pay
);
    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] pay_q;

    // Take fresh unit parameters at slot 0; keep the latched ones for later slots.
    always_comb begin
        unit_start = (pos_q == '0);
        pos        = pos_q;
        eff_len    = unit_start ? len_new : len_q;
        eff_pay    = unit_start ? pay_new : pay_q;
    end

    // Advance the slot index; wrap it at the unit boundary and latch the parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            len_q <= '0;
            pay_q <= '0;
        end else begin
            if (unit_start) begin
                len_q <= len_new;
                pay_q <= pay_new;
            end
            if (pos_q == eff_len - LEN_W'(1))
                pos_q <= '0;
            else
                pos_q <= pos_q + LEN_W'(1);
        end
    end
endmodule

// File: rtl/tu_sym_mux.sv
// Symbol selector. It classifies the current slot as payload, fill-start, zero
// stuffing or fill-end, and registers the chosen link symbol.
// Assumes: pay <= len, and pos < len.
module tu_sym_mux
    import tu_pkg::*;
#(
    parameter int              LEN_W   = 7,
    parameter int              DATA_W  = 8,
    parameter logic [DATA_W-1:0] FS_CODE = 8'hF1,
    parameter logic [DATA_W-1:0] FE_CODE = 8'hF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  pos,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  pay,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sym,
    output logic              out_ctrl,
    output logic              out_underflow
);
    slot_t kind;

    // Slot kind: payload first, fill-end last, fill-start right after the payload.
    always_comb begin
        if (pos < pay)
            kind = SLOT_PAY;
        else if (pos == len - LEN_W'(1))
            kind = SLOT_FE;
        else if (pos == pay)
            kind = SLOT_FS;
        else
            kind = SLOT_ZERO;
        in_ready = (kind == SLOT_PAY);
    end

    // Register the link symbol for this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_sym       <= '0;
            out_ctrl      <= 1'b0;
            out_underflow <= 1'b0;
        end else begin
            out_valid     <= 1'b1;
            out_underflow <= 1'b0;
            out_ctrl      <= 1'b0;
            out_sym       <= '0;
            case (kind)
                SLOT_PAY: begin
                    if (in_valid) out_sym <= in_data;
                    else          out_underflow <= 1'b1;
                end
                SLOT_FS: begin
                    out_sym  <= FS_CODE;
                    out_ctrl <= 1'b1;
                end
                SLOT_FE: begin
                    out_sym  <= FE_CODE;
                    out_ctrl <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tu_packer.sv
// Transfer unit payload packer, top level. It clamps the requested unit length,
// derives a per-unit payload count from the fractional ratio, and emits one
// framed link symbol per clock.
// Assumes: configuration is held steady while a unit is in progress.
module tu_packer #(
    parameter int                DATA_W  = 8,
    parameter int                FRAC_W  = 8,
    parameter int                MIN_TU  = 32,
    parameter int                MAX_TU  = 64,
    parameter logic [DATA_W-1:0] FS_CODE = 8'hF1,
    parameter logic [DATA_W-1:0] FE_CODE = 8'hF2,
    localparam int               LEN_W   = $clog2(MAX_TU + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_tu_len,
    input  logic [LEN_W-1:0]  cfg_pay_int,
    input  logic [FRAC_W-1:0] cfg_pay_frac,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sym,
    output logic              out_ctrl,
    output logic              out_underflow
);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_TU);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_TU);

    logic [LEN_W-1:0] len_clamped;
    logic [LEN_W-1:0] pay_new;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] eff_pay;
    logic             unit_start;

    // Clamp the requested unit length into the supported range.
    always_comb begin
        if (cfg_tu_len < MIN_L)      len_clamped = MIN_L;
        else if (cfg_tu_len > MAX_L) len_clamped = MAX_L;
        else                         len_clamped = cfg_tu_len;
    end

    tu_ratio_acc #(.LEN_W(LEN_W), .FRAC_W(FRAC_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (unit_start),
        .pay_int  (cfg_pay_int),
        .pay_frac (cfg_pay_frac),
        .unit_len (len_clamped),
        .pay_cnt  (pay_new)
    );

    tu_slot_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_new    (len_clamped),
        .pay_new    (pay_new),
        .unit_start (unit_start),
        .pos        (pos),
        .eff_len    (eff_len),
        .eff_pay    (eff_pay)
    );

    tu_sym_mux #(
        .LEN_W(LEN_W), .DATA_W(DATA_W), .FS_CODE(FS_CODE), .FE_CODE(FE_CODE)
    ) u_mux (
        .clk           (clk),
        .rst_n         (rst_n),
        .pos           (pos),
        .len           (eff_len),
        .pay           (eff_pay),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .out_valid     (out_valid),
        .out_sym       (out_sym),
        .out_ctrl      (out_ctrl),
        .out_underflow (out_underflow)
    );
endmodule

// File: rtl/tu_packer_chk.sv
// Checker for the transfer unit packer: temporal properties on its ports.
// Assumes: attached to every tu_packer instance through the bind below.
module tu_packer_chk #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] FS_CODE = 8'hF1,
    parameter logic [DATA_W-1:0] FE_CODE = 8'hF2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sym,
    input logic              out_ctrl,
    input logic              out_underflow
);
    AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_underflow |-> (out_sym == '0 && !out_ctrl && out_valid)); // R9

    AST_UFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_underflow |-> $past(in_ready && !in_valid)); // R9

    AST_PAY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (out_valid && !out_ctrl && !out_underflow)); // R10

    AST_CTRL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_ctrl |-> (out_sym == FS_CODE || out_sym == FE_CODE)); // R5

    AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ctrl && out_sym == FS_CODE) |=> !(out_ctrl && out_sym == FS_CODE)); // R5

    AST_NO_CTRL_IN_PAY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !out_ctrl); // R8
endmodule

bind tu_packer tu_packer_chk #(
    .DATA_W(DATA_W), .FS_CODE(FS_CODE), .FE_CODE(FE_CODE)
) u_tu_packer_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_sym       (out_sym),
    .out_ctrl      (out_ctrl),
    .out_underflow (out_underflow)
);

// File: tb/tu_packer_bench.sv
// Bench for the transfer unit packer: behavioural slot model, compared every clock.
module tu_packer_bench;
    localparam int DW = 8;
    localparam int LW = 7;
    localparam logic [7:0] FS = 8'hF1;
    localparam logic [7:0] FE = 8'hF2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LW-1:0] cfg_tu_len = 7'd40;
    logic [LW-1:0] cfg_pay_int = 7'd20;
    logic [7:0]    cfg_pay_frac = 8'd0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_sym;
    logic          out_ctrl;
    logic          out_underflow;

    int checks = 0;
    int failures = 0;

    // model state
    int  m_pos, m_acc, m_len, m_pay, cyc, last_fe, ready_cnt;
    logic [7:0] src;
    logic [7:0] e_sym;
    logic       e_valid, e_ctrl, e_uf;
    string      e_tag;

    always #4 clk = ~clk;   // 125 MHz

    tu_packer u_tu_packer (
        .clk(clk), .rst_n(rst_n), .cfg_tu_len(cfg_tu_len), .cfg_pay_int(cfg_pay_int),
        .cfg_pay_frac(cfg_pay_frac), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_sym(out_sym),
        .out_ctrl(out_ctrl), .out_underflow(out_underflow)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic do_reset(input int len, input int pint, input int pfrac);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        cfg_tu_len = LW'(len);
        cfg_pay_int = LW'(pint);
        cfg_pay_frac = 8'(pfrac);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_ctrl == 1'b0 && out_underflow == 1'b0 && out_sym == '0,
            "R1 reset outputs", {out_valid, out_ctrl, out_underflow, out_sym}, 0);
        rst_n = 1'b1;
        m_pos = 0; m_acc = 0; last_fe = -1; ready_cnt = 0; src = 8'h01; cyc = 0;
        e_valid = 1'b0; e_sym = '0; e_ctrl = 1'b0; e_uf = 1'b0; e_tag = "R1 first cycle";
    endtask

    task automatic run(input int ncyc, input bit gaps, input int exp_len);
        for (int i = 0; i < ncyc; i++) begin
            in_valid = gaps ? ((cyc % 5) != 2) : 1'b1;
            in_data  = src;
            #1;
            if (m_pos == 0) begin
                int s;
                m_len = (cfg_tu_len < 32) ? 32 : ((cfg_tu_len > 64) ? 64 : int'(cfg_tu_len));
                s = m_acc + int'(cfg_pay_frac);
                m_pay = int'(cfg_pay_int) + ((s >= 256) ? 1 : 0);
                m_acc = s % 256;
                if (m_pay > m_len) m_pay = m_len;   // R7 clamp
            end
            chk(in_ready == (m_pos < m_pay), "R8 in_ready", in_ready, (m_pos < m_pay));
            e_valid = 1'b1; e_ctrl = 1'b0; e_uf = 1'b0; e_sym = '0;
            if (m_pos < m_pay) begin
                ready_cnt++;
                if (in_valid) begin
                    e_sym = src; src = src + 8'd1; e_tag = "R3 R10 payload";
                end else begin
                    e_uf = 1'b1; e_tag = "R9 underflow";
                end
            end else if (m_pos == m_len - 1) begin
                e_sym = FE; e_ctrl = 1'b1;
                e_tag = (m_len - m_pay == 1) ? "R6 fill-end only" : "R5 fill-end";
                if (last_fe >= 0)
                    chk(cyc - last_fe == exp_len, "R2 unit length", cyc - last_fe, exp_len);
                last_fe = cyc;
            end else if (m_pos == m_pay) begin
                e_sym = FS; e_ctrl = 1'b1; e_tag = "R5 fill-start";
            end else begin
                e_tag = "R5 zero stuffing";
            end
            m_pos = (m_pos == m_len - 1) ? 0 : m_pos + 1;
            @(negedge clk);
            chk(out_valid == e_valid && out_sym == e_sym && out_ctrl == e_ctrl && out_underflow == e_uf,
                e_tag, {out_valid, out_ctrl, out_underflow, out_sym}, {e_valid, e_ctrl, e_uf, e_sym});
            cyc++;
        end
    endtask

    initial begin
        // R4: alternating carry, 8 units of 40 -> 8*20 + 4
        do_reset(40, 20, 128);
        run(8 * 40, 1'b0, 40);
        chk(ready_cnt == 164, "R4 payload total 40/20.5", ready_cnt, 164);
        // R6: one stuffing slot
        do_reset(32, 31, 0);
        run(4 * 32, 1'b0, 32);
        chk(ready_cnt == 124, "R6 payload total", ready_cnt, 124);
        // R7: ratio above length, full units
        do_reset(64, 70, 64);
        run(4 * 64, 1'b0, 64);
        chk(ready_cnt == 256, "R7 clamped payload total", ready_cnt, 256);
        // R2 low clamp plus R9 underflow gaps
        do_reset(20, 10, 85);
        run(6 * 32, 1'b1, 32);
        chk(ready_cnt == 61, "R4 payload total 32/10.33", ready_cnt, 61);
        // R2 high clamp
        do_reset(100, 33, 192);
        run(5 * 64, 1'b0, 64);
        chk(ready_cnt == 168, "R4 payload total 64/33.75", ready_cnt, 168);
        // R5: stuffing of exactly two slots
        do_reset(32, 30, 0);
        run(3 * 32, 1'b1, 32);
        chk(ready_cnt == 90, "R5 payload total two-slot stuffing", ready_cnt, 90);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule